// File: doc/BRIEF.md
# IEEE 802.15.4 PHY Frame Formatter

This block is the transmit-side framer of a low-rate wireless PHY. Once a host has placed a payload in a buffer and set its length, a single start pulse makes the block emit a complete PHY frame, one byte per cycle, towards a downstream chip spreader. Four zero preamble bytes come first, then a fixed start-of-frame delimiter and a length byte. The payload follows, fetched from the buffer through a ready/valid read port. A two-byte frame check sequence computed over the payload closes the frame.

Every output byte carries a valid flag. The final byte carries a last flag, and a done pulse marks the end of the frame. A requested length larger than the format allows is refused with a one-cycle error pulse, and no byte goes out for it. Chip spreading, modulation and receive parsing belong to other blocks.

Top module: `txf_framer`

## Requirements
- R1: While `rst_n` is low, `out_vld_o`, `out_last_o`, `done_o`, `err_o` and `pl_rdy_o` are all 0.
- R2: A start pulse seen in idle with `len_i` <= 125 gives four preamble bytes of value 0x00 on consecutive cycles. The first of them is valid in the second cycle after the clock edge that samples `start_i` (`out_vld_o` is still 0 in the first cycle).
- R3: The cycle after the last preamble byte carries the delimiter byte 0xA7.
- R4: The cycle after the delimiter carries the length byte, whose value is `len_i` + 2 (the payload count plus the two check bytes).
- R5: `pl_rdy_o` is 1 only while payload bytes are owed. Each cycle with `pl_rdy_o` and `pl_vld_i` both 1 moves `pl_data_i` to the output one cycle later, in buffer order. A cycle with `pl_rdy_o` 1 and `pl_vld_i` 0 leaves `out_vld_o` at 0 in the next cycle.
- R6: After the payload come two check bytes holding a CRC-16 with generator x^16+x^12+x^5+1 and start value 0x0000. Each payload byte is fed least significant bit first, which is a right-shifting register with feedback constant 0x8408. Only payload bytes are covered. The low byte of the register is sent first and the high byte second, and the high byte carries `out_last_o` = 1.
- R7: `done_o` is a one-cycle pulse in the same cycle as the final check byte and is 0 at every other time.
- R8: A start pulse seen in idle with `len_i` > 125 raises `err_o` for exactly one cycle, in the cycle after the sampling edge. No output byte follows and `pl_rdy_o` stays 0.
- R9: A start pulse seen while a frame is in progress is ignored: the frame in progress continues unchanged and no further frame follows it.
- R10: A length of 0 gives a frame of preamble, delimiter, length byte 0x02 and the check bytes 0x00, 0x00, with no payload request.
- R11: Outside payload waiting, the frame bytes are valid on consecutive cycles. `out_last_o` is 1 only on the final byte, and `out_vld_o` is 0 in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to send one frame |
| len_i | input | 7 | Payload byte count for the request |
| pl_rdy_o | output | 1 | Framer ready to take a payload byte |
| pl_vld_i | input | 1 | Payload byte offered by the buffer |
| pl_data_i | input | 8 | Payload byte |
| out_vld_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output frame byte |
| out_last_o | output | 1 | Final byte of the frame |
| done_o | output | 1 | Frame complete pulse |
| err_o | output | 1 | Length refused pulse |

## Verification
On every cycle the assertions check several rules. The done pulse must coincide with a valid last byte. A refusal must leave the output and the payload request quiet. An unserved payload request must produce an output gap, and a frame end must be followed by an idle cycle. Byte values can only be shown by the bench's scenarios: the preamble and delimiter contents, the length arithmetic, the payload order under stalls, and the check bytes compared with an independently computed CRC. The same holds for the empty-payload frame, the maximum length, the refused length and a start request arriving mid-frame.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SFD,
    ST_LEN,
    ST_PAY,
    ST_FCS
  } txf_state_e;

  // One byte into a right-shifting CRC register, least significant bit first.
  function automatic logic [15:0] crc_step_byte(input logic [15:0] crc_in,
                                                input logic [7:0]  dat,
                                                input logic [15:0] poly_rev);
    logic [15:0] c;
    c = crc_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ dat[b]) c = (c >> 1) ^ poly_rev;
      else               c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/txf_crc16.sv
module txf_crc16 #(
  parameter int          DW       = 8,
  parameter logic [15:0] POLY_REV = 16'h8408,
  parameter logic [15:0] SEED     = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] byte_i,
  output logic [15:0]   crc_o
);
  import txf_pkg::*;

  logic [15:0] crc_q, crc_d;
  logic        crc_en;

  assign crc_en = clr_i | en_i;

  always_comb begin
    if (clr_i) crc_d = SEED;
    else       crc_d = crc_step_byte(crc_q, byte_i[7:0], POLY_REV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SEED;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/txf_ctrl.sv
module txf_ctrl #(
  parameter int PRE_LEN   = 4,
  parameter int MAX_PAY   = 125,
  parameter int FCS_BYTES = 2,
  parameter int LEN_W     = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                pl_vld_i,
  output txf_pkg::txf_state_e state_o,
  output logic [LEN_W-1:0]    cnt_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                err_o
);
  import txf_pkg::*;

  localparam logic [LEN_W-1:0] PRE_END = LEN_W'(PRE_LEN - 1);
  localparam logic [LEN_W-1:0] FCS_END = LEN_W'(FCS_BYTES - 1);
  localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(MAX_PAY);

  txf_state_e       st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q;
  logic             err_q, err_d;
  logic             accept, len_ok;

  assign len_ok = (len_i <= LEN_MAX);
  assign accept = (st_q == ST_IDLE) && start_i && len_ok;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    err_d = (st_q == ST_IDLE) && start_i && !len_ok;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        st_d  = ST_PRE;
        cnt_d = '0;
      end
      ST_PRE: begin
        if (cnt_q == PRE_END) begin
          st_d  = ST_SFD;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SFD: st_d = ST_LEN;
      ST_LEN: begin
        st_d  = (len_q == '0) ? ST_FCS : ST_PAY;
        cnt_d = '0;
      end
      ST_PAY: if (pl_vld_i) begin
        if (cnt_q == len_q - 1'b1) begin
          st_d  = ST_FCS;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FCS: begin
        if (cnt_q == FCS_END) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (accept) len_q <= len_i;
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;
  assign len_o   = len_q;
  assign err_o   = err_q;
endmodule

// File: rtl/txf_framer.sv
module txf_framer #(
  parameter int          DW        = 8,
  parameter int          PRE_LEN   = 4,
  parameter int          MAX_PAY   = 125,
  parameter int          FCS_BYTES = 2,
  parameter logic [7:0]  PRE_VAL   = 8'h00,
  parameter logic [7:0]  SFD_VAL   = 8'hA7,
  parameter logic [15:0] POLY_REV  = 16'h8408,
  parameter int          LEN_W     = $clog2(MAX_PAY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             pl_rdy_o,
  input  logic             pl_vld_i,
  input  logic [DW-1:0]    pl_data_i,
  output logic             out_vld_o,
  output logic [DW-1:0]    out_data_o,
  output logic             out_last_o,
  output logic             done_o,
  output logic             err_o
);
  import txf_pkg::*;

  localparam logic [LEN_W-1:0] FCS_END = LEN_W'(FCS_BYTES - 1);

  txf_state_e       state;
  logic [LEN_W-1:0] cnt, len_q;
  logic [15:0]      crc;
  logic             emit, is_last, crc_en, crc_clr;
  logic [DW-1:0]    byte_d;
  logic [DW-1:0]    dat_q;
  logic             vld_q, last_q, done_q;

  txf_ctrl #(
    .PRE_LEN  (PRE_LEN),
    .MAX_PAY  (MAX_PAY),
    .FCS_BYTES(FCS_BYTES),
    .LEN_W    (LEN_W)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .len_i   (len_i),
    .pl_vld_i(pl_vld_i),
    .state_o (state),
    .cnt_o   (cnt),
    .len_o   (len_q),
    .err_o   (err_o)
  );

  assign crc_clr = (state == ST_IDLE);
  assign crc_en  = (state == ST_PAY) && pl_vld_i;

  txf_crc16 #(
    .DW      (DW),
    .POLY_REV(POLY_REV),
    .SEED    (16'h0000)
  ) crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (crc_clr),
    .en_i  (crc_en),
    .byte_i(pl_data_i),
    .crc_o (crc)
  );

  always_comb begin
    byte_d = '0;
    unique case (state)
      ST_PRE:  byte_d = DW'(PRE_VAL);
      ST_SFD:  byte_d = DW'(SFD_VAL);
      ST_LEN:  byte_d = DW'(len_q) + DW'(FCS_BYTES);
      ST_PAY:  byte_d = pl_data_i;
      ST_FCS:  byte_d = (cnt == '0) ? DW'(crc[7:0]) : DW'(crc[15:8]);
      default: byte_d = '0;
    endcase
  end

  assign pl_rdy_o = (state == ST_PAY);
  assign emit     = (state != ST_IDLE) && ((state != ST_PAY) || pl_vld_i);
  assign is_last  = (state == ST_FCS) && (cnt == FCS_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= emit;
      last_q <= emit && is_last;
      done_q <= emit && is_last;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dat_q <= '0;
    else if (emit) dat_q <= byte_d;
  end

  assign out_vld_o  = vld_q;
  assign out_data_o = dat_q;
  assign out_last_o = last_q;
  assign done_o     = done_q;
endmodule

// File: rtl/txf_framer_chk.sv
module txf_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic pl_rdy_o,
  input logic pl_vld_i,
  input logic out_vld_o,
  input logic out_last_o,
  input logic done_o,
  input logic err_o
);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      a_reset_quiet_r1: assert (!out_vld_o && !out_last_o && !done_o && !err_o && !pl_rdy_o)
        else $error("outputs active during reset");
    end
  end

  p_payload_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_rdy_o && !pl_vld_i) |=> !out_vld_o);

  p_done_with_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (out_vld_o && out_last_o));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!out_vld_o && !pl_rdy_o));

  p_err_nothing_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (!out_vld_o && !pl_rdy_o));

  p_last_is_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> out_vld_o);

  p_idle_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |=> !out_vld_o);

endmodule

bind txf_framer txf_framer_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .pl_rdy_o  (pl_rdy_o),
  .pl_vld_i  (pl_vld_i),
  .out_vld_o (out_vld_o),
  .out_last_o(out_last_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/txf_framer_tb_top.sv
`timescale 1ns/1ps
module txf_framer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i;
  logic [6:0] len_i;
  logic       pl_rdy_o;
  logic       pl_vld_i;
  logic [7:0] pl_data_i;
  logic       out_vld_o;
  logic [7:0] out_data_o;
  logic       out_last_o;
  logic       done_o;
  logic       err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  logic [7:0] pay_mem [128];
  int         idx = 0;
  bit         stall_mode = 0;
  int         cyc = 0;

  always #2 clk = ~clk;

  txf_framer dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .len_i     (len_i),
    .pl_rdy_o  (pl_rdy_o),
    .pl_vld_i  (pl_vld_i),
    .pl_data_i (pl_data_i),
    .out_vld_o (out_vld_o),
    .out_data_o(out_data_o),
    .out_last_o(out_last_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h0000;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ pay_mem[i][b];
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
      end
    end
    return c;
  endfunction

  // buffer model: offers bytes at the falling edge
  always @(negedge clk) begin
    bit v;
    cyc++;
    v = stall_mode ? ((cyc % 3) != 2) : 1'b1;
    pl_vld_i  <= v;
    pl_data_i <= pay_mem[idx];
    if (v && pl_rdy_o) idx++;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (out_vld_o) begin
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected byte", int'(out_data_o), 0);
        end else begin
          logic [8:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data_o == e[7:0], t, int'(out_data_o), int'(e[7:0]));
          check(out_last_o == e[8], {t, " last R11"}, int'(out_last_o), int'(e[8]));
          check(done_o == e[8], "R7 done with last", int'(done_o), int'(e[8]));
        end
      end else if (done_o || out_last_o) begin
        check(0, "R7 done/last without valid", int'({done_o, out_last_o}), 0);
      end
    end
  end

  task automatic push(input logic [7:0] d, input bit last, input string t);
    exp_q.push_back({last, d});
    tag_q.push_back(t);
  endtask

  task automatic send_frame(input int n, input int seed, input bit stall, input bit poke);
    logic [15:0] c;
    for (int i = 0; i < 128; i++) pay_mem[i] = 8'((seed * 37 + i * (seed + 3)) ^ (i << 2));
    c = ref_crc(n);
    for (int i = 0; i < 4; i++) push(8'h00, 0, "R2 preamble");
    push(8'hA7, 0, "R3 delimiter");
    push(8'(n + 2), 0, (n == 0) ? "R10 length" : "R4 length");
    for (int i = 0; i < n; i++) push(pay_mem[i], 0, "R5 payload");
    push(c[7:0], 0, (n == 0) ? "R10 fcs low" : "R6 fcs low");
    push(c[15:8], 1, (n == 0) ? "R10 fcs high" : "R6 fcs high");
    stall_mode = stall;
    idx = 0;
    @(negedge clk);
    start_i = 1'b1;
    len_i   = 7'(n);
    @(negedge clk);
    start_i = 1'b0;
    check(out_vld_o == 1'b0, "R2 latency first cycle", int'(out_vld_o), 0);
    @(negedge clk);
    check(out_vld_o == 1'b1, "R2 latency second cycle", int'(out_vld_o), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start_i = 1'b1;
      len_i   = 7'd2;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    if (n == 0) check(idx == 0, "R10 no payload taken", idx, 0);
    else        check(idx == n, "R5 payload count", idx, n);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    rst_n    = 1'b0;
    start_i  = 1'b0;
    len_i    = '0;
    pl_vld_i = 1'b0;
    pl_data_i = '0;
    for (int i = 0; i < 128; i++) pay_mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!out_vld_o && !out_last_o && !done_o && !err_o && !pl_rdy_o, "R1 reset quiet",
          int'({out_vld_o, out_last_o, done_o, err_o, pl_rdy_o}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    send_frame(5, 1, 0, 0);
    send_frame(0, 2, 0, 0);
    send_frame(125, 3, 1, 0);
    send_frame(1, 4, 0, 1);   // R9 start while busy
    send_frame(3, 9, 1, 0);

    // R8 refused length
    @(negedge clk);
    start_i = 1'b1;
    len_i   = 7'd126;
    @(negedge clk);
    start_i = 1'b0;
    check(err_o == 1'b1, "R8 error pulse", int'(err_o), 1);
    check(pl_rdy_o == 1'b0, "R8 no payload request", int'(pl_rdy_o), 0);
    @(negedge clk);
    check(err_o == 1'b0, "R8 error one cycle", int'(err_o), 0);
    for (int i = 0; i < 8; i++) begin
      check(!out_vld_o && !pl_rdy_o, "R8 nothing sent", int'({out_vld_o, pl_rdy_o}), 0);
      @(negedge clk);
    end

    send_frame(2, 7, 0, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule